// File: doc/BRIEF.md
# Fetch-and-Add Combining Switch Node

This block is one two-input node of a processor-to-memory interconnect. It performs fetch-and-add combining inside the network and not in the memory. Two requesters may present a request in the same cycle. If both are fetch-and-add operations to the same address, the node sends one upstream fetch-and-add whose increment is the sum of the two increments. It also keeps the increment of input 0 in a small tagged wait buffer.

When the single reply for a combined request returns with old value `v`, the node splits it into two responses. Input 0 receives `v` and input 1 receives `v + inc0`. This is the outcome of input 0's add running just before input 1's add. Any pair that cannot be combined is forwarded one request per cycle, with input 0 first.

Loads and stores pass through unchanged. Every upstream and downstream channel uses a valid/ready handshake. A response is held until its requester accepts it.

Top module: `fa_comb_switch`

## Requirements
- R1: When both inputs are valid in one cycle, both carry the fetch-and-add opcode (2'b10), their addresses are equal, and the wait buffer has a free entry, the node issues one upstream fetch-and-add. That request carries the shared address and the sum of both increments. Both inputs see ready in that same cycle.
- R2: A reply with value `v` to a combined request produces two responses one cycle after the reply is accepted. Input 0 receives `v` and input 1 receives `v + inc0`, modulo 2^DATA_W.
- R3: Requests that are not combined are forwarded one per cycle, and input 0 has priority. Input 1 sees ready only when input 0 is idle or the pair is being combined.
- R4: Two requests are never combined when either opcode is not fetch-and-add (load 2'b00, store 2'b01) or when the addresses differ.
- R5: When every wait-buffer entry is in use, combining stops and forwarding continues.
- R6: The upstream tag has width log2(WB_DEPTH)+1. The top bit set means "combined", and the low bits then give the wait-buffer entry. The top bit clear means "forwarded", and bit 0 then gives the source input. The reply tag routes the reply and selects the entry that is freed.
- R7: A response stays valid with stable data until its ready is seen. The reply channel is not ready while a slot that the reply needs is still occupied.
- R8: After reset no output valid is asserted and the wait buffer is empty.
- R9: After all requests complete, memory holds the value that executing every request serially gives, and the returned values match that same order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req0_valid_i | input | 1 | Input 0 request valid |
| req0_ready_o | output | 1 | Input 0 request accepted |
| req0_op_i | input | 2 | Input 0 opcode |
| req0_addr_i | input | ADDR_W | Input 0 address |
| req0_data_i | input | DATA_W | Input 0 increment or store data |
| req1_valid_i | input | 1 | Input 1 request valid |
| req1_ready_o | output | 1 | Input 1 request accepted |
| req1_op_i | input | 2 | Input 1 opcode |
| req1_addr_i | input | ADDR_W | Input 1 address |
| req1_data_i | input | DATA_W | Input 1 increment or store data |
| up_valid_o | output | 1 | Upstream request valid |
| up_ready_i | input | 1 | Upstream request accepted |
| up_op_o | output | 2 | Upstream opcode |
| up_addr_o | output | ADDR_W | Upstream address |
| up_data_o | output | DATA_W | Upstream data (summed increment if combined) |
| up_tag_o | output | log2(WB_DEPTH)+1 | Upstream routing tag |
| up_rsp_valid_i | input | 1 | Upstream reply valid |
| up_rsp_ready_o | output | 1 | Upstream reply accepted |
| up_rsp_tag_i | input | log2(WB_DEPTH)+1 | Reply tag |
| up_rsp_data_i | input | DATA_W | Old memory value |
| rsp0_valid_o | output | 1 | Input 0 response valid |
| rsp0_ready_i | input | 1 | Input 0 response accepted |
| rsp0_data_o | output | DATA_W | Input 0 returned value |
| rsp1_valid_o | output | 1 | Input 1 response valid |
| rsp1_ready_i | input | 1 | Input 1 response accepted |
| rsp1_data_o | output | DATA_W | Input 1 returned value |

## Verification
Combining is tried against four input patterns:
- A same-address fetch-and-add pair, which must merge.
- A same-address load pair.
- A fetch-and-add pair to different addresses.
- A fetch-and-add paired with a load to the same address.

The last three must stay separate, so they tell a correct match condition apart from one that checks only address or only opcode. A run of repeated pairs to one address with replies withheld fills the wait buffer. The value sequence returned on each input then shows whether combining stops exactly at the full point and whether decombining applies the right stored increment. A response held by backpressure while a second reply waits tells a held output apart from an overwritten one.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
  typedef enum logic [1:0] {
    OP_LOAD  = 2'd0,
    OP_STORE = 2'd1,
    OP_FAA   = 2'd2
  } fcs_op_e;
endpackage

// File: rtl/fcs_req_merge.sv
module fcs_req_merge
  import fcs_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned WB_DEPTH = 4,
  localparam int unsigned IDX_W   = $clog2(WB_DEPTH),
  localparam int unsigned TAG_W   = IDX_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              v0_i,
  output logic              r0_o,
  input  logic [1:0]        op0_i,
  input  logic [ADDR_W-1:0] addr0_i,
  input  logic [DATA_W-1:0] data0_i,
  input  logic              v1_i,
  output logic              r1_o,
  input  logic [1:0]        op1_i,
  input  logic [ADDR_W-1:0] addr1_i,
  input  logic [DATA_W-1:0] data1_i,
  input  logic              wb_full_i,
  input  logic [IDX_W-1:0]  wb_free_idx_i,
  output logic              wb_alloc_o,
  output logic [DATA_W-1:0] wb_inc_o,
  output logic              up_valid_o,
  input  logic              up_ready_i,
  output logic [1:0]        up_op_o,
  output logic [ADDR_W-1:0] up_addr_o,
  output logic [DATA_W-1:0] up_data_o,
  output logic [TAG_W-1:0]  up_tag_o
);
  logic pair_match, combine;

  assign pair_match = v0_i && v1_i
                   && (op0_i == OP_FAA) && (op1_i == OP_FAA)
                   && (addr0_i == addr1_i);
  assign combine    = pair_match && !wb_full_i;

  always_comb begin
    up_valid_o = v0_i || v1_i;
    r0_o       = 1'b0;
    r1_o       = 1'b0;
    up_op_o    = op0_i;
    up_addr_o  = addr0_i;
    up_data_o  = data0_i;
    up_tag_o   = '0;
    if (combine) begin
      up_op_o   = OP_FAA;
      up_data_o = data0_i + data1_i;
      up_tag_o  = {1'b1, wb_free_idx_i};
      r0_o      = up_ready_i;
      r1_o      = up_ready_i;
    end else if (v0_i) begin
      r0_o      = up_ready_i;
    end else if (v1_i) begin
      up_op_o   = op1_i;
      up_addr_o = addr1_i;
      up_data_o = data1_i;
      up_tag_o  = {1'b0, IDX_W'(1)};
      r1_o      = up_ready_i;
    end
  end

  assign wb_alloc_o = combine && up_ready_i;
  assign wb_inc_o   = data0_i;

  // R3: input 1 never overtakes a waiting input 0 unless merged
  assert_in0_priority_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (v0_i && r1_o) |-> (r0_o && up_tag_o[TAG_W-1]));

  // R4: a combined tag only appears for a matching fetch-and-add pair
  assert_match_only_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_valid_o && up_tag_o[TAG_W-1]) |->
      (op0_i == OP_FAA && op1_i == OP_FAA && addr0_i == addr1_i && v0_i && v1_i));
endmodule

// File: rtl/fcs_wait_buf.sv
module fcs_wait_buf #(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned WB_DEPTH = 4,
  localparam int unsigned IDX_W   = $clog2(WB_DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              alloc_i,
  input  logic [IDX_W-1:0]  alloc_idx_i,
  input  logic [DATA_W-1:0] alloc_inc_i,
  input  logic              rel_i,
  input  logic [IDX_W-1:0]  rel_idx_i,
  output logic [DATA_W-1:0] rel_inc_o,
  output logic              full_o,
  output logic [IDX_W-1:0]  free_idx_o
);
  logic [WB_DEPTH-1:0] busy_q;
  logic [DATA_W-1:0]   inc_q [WB_DEPTH];

  always_comb begin
    full_o     = 1'b1;
    free_idx_o = '0;
    for (int i = WB_DEPTH - 1; i >= 0; i--) begin
      if (!busy_q[i]) begin
        full_o     = 1'b0;
        free_idx_o = IDX_W'(i);
      end
    end
  end

  assign rel_inc_o = inc_q[rel_idx_i];

  for (genvar g = 0; g < WB_DEPTH; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        busy_q[g] <= 1'b0;
        inc_q[g]  <= '0;
      end else if (alloc_i && alloc_idx_i == IDX_W'(g)) begin
        busy_q[g] <= 1'b1;
        inc_q[g]  <= alloc_inc_i;
      end else if (rel_i && rel_idx_i == IDX_W'(g)) begin
        busy_q[g] <= 1'b0;
      end
    end
  end

  // R5: never allocate into a full buffer
  assert_no_alloc_full_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_i |-> !busy_q[alloc_idx_i]);

  // R6: a combined reply must name a pending entry
  assert_rel_pending_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rel_i |-> busy_q[rel_idx_i]);
endmodule

// File: rtl/fcs_rsp_split.sv
module fcs_rsp_split #(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned WB_DEPTH = 4,
  localparam int unsigned IDX_W   = $clog2(WB_DEPTH),
  localparam int unsigned TAG_W   = IDX_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              up_rsp_valid_i,
  output logic              up_rsp_ready_o,
  input  logic [TAG_W-1:0]  up_rsp_tag_i,
  input  logic [DATA_W-1:0] up_rsp_data_i,
  output logic              rel_o,
  output logic [IDX_W-1:0]  rel_idx_o,
  input  logic [DATA_W-1:0] rel_inc_i,
  output logic              rsp0_valid_o,
  input  logic              rsp0_ready_i,
  output logic [DATA_W-1:0] rsp0_data_o,
  output logic              rsp1_valid_o,
  input  logic              rsp1_ready_i,
  output logic [DATA_W-1:0] rsp1_data_o
);
  logic is_comb, to_port1, accept, load0, load1;

  assign is_comb   = up_rsp_tag_i[TAG_W-1];
  assign to_port1  = up_rsp_tag_i[0];
  assign rel_idx_o = up_rsp_tag_i[IDX_W-1:0];

  always_comb begin
    if (is_comb)       up_rsp_ready_o = !rsp0_valid_o && !rsp1_valid_o;
    else if (to_port1) up_rsp_ready_o = !rsp1_valid_o;
    else               up_rsp_ready_o = !rsp0_valid_o;
  end

  assign accept = up_rsp_valid_i && up_rsp_ready_o;
  assign rel_o  = accept && is_comb;
  assign load0  = accept && (is_comb || !to_port1);
  assign load1  = accept && (is_comb || to_port1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp0_valid_o <= 1'b0;
      rsp0_data_o  <= '0;
      rsp1_valid_o <= 1'b0;
      rsp1_data_o  <= '0;
    end else begin
      if (load0) begin
        rsp0_valid_o <= 1'b1;
        rsp0_data_o  <= up_rsp_data_i;
      end else if (rsp0_ready_i) begin
        rsp0_valid_o <= 1'b0;
      end
      if (load1) begin
        rsp1_valid_o <= 1'b1;
        rsp1_data_o  <= is_comb ? up_rsp_data_i + rel_inc_i : up_rsp_data_i;
      end else if (rsp1_ready_i) begin
        rsp1_valid_o <= 1'b0;
      end
    end
  end

  // R7: a stalled response keeps its value
  assert_rsp0_held_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp0_valid_o && !rsp0_ready_i) |=> (rsp0_valid_o && $stable(rsp0_data_o)));
  assert_rsp1_held_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp1_valid_o && !rsp1_ready_i) |=> (rsp1_valid_o && $stable(rsp1_data_o)));

  // R2: a combined reply raises both responses together
  assert_split_both_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rel_o |=> (rsp0_valid_o && rsp1_valid_o));
endmodule

// File: rtl/fa_comb_switch.sv
module fa_comb_switch
  import fcs_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned WB_DEPTH = 4
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        req0_valid_i,
  output logic                        req0_ready_o,
  input  logic [1:0]                  req0_op_i,
  input  logic [ADDR_W-1:0]           req0_addr_i,
  input  logic [DATA_W-1:0]           req0_data_i,
  input  logic                        req1_valid_i,
  output logic                        req1_ready_o,
  input  logic [1:0]                  req1_op_i,
  input  logic [ADDR_W-1:0]           req1_addr_i,
  input  logic [DATA_W-1:0]           req1_data_i,
  output logic                        up_valid_o,
  input  logic                        up_ready_i,
  output logic [1:0]                  up_op_o,
  output logic [ADDR_W-1:0]           up_addr_o,
  output logic [DATA_W-1:0]           up_data_o,
  output logic [$clog2(WB_DEPTH):0]   up_tag_o,
  input  logic                        up_rsp_valid_i,
  output logic                        up_rsp_ready_o,
  input  logic [$clog2(WB_DEPTH):0]   up_rsp_tag_i,
  input  logic [DATA_W-1:0]           up_rsp_data_i,
  output logic                        rsp0_valid_o,
  input  logic                        rsp0_ready_i,
  output logic [DATA_W-1:0]           rsp0_data_o,
  output logic                        rsp1_valid_o,
  input  logic                        rsp1_ready_i,
  output logic [DATA_W-1:0]           rsp1_data_o
);
  localparam int unsigned IDX_W = $clog2(WB_DEPTH);

  logic              wb_full, wb_alloc, wb_rel;
  logic [IDX_W-1:0]  wb_free_idx, wb_rel_idx;
  logic [DATA_W-1:0] wb_inc_in, wb_inc_out;

  fcs_req_merge #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WB_DEPTH(WB_DEPTH)) u_merge (
    .clk_i, .rst_ni,
    .v0_i(req0_valid_i), .r0_o(req0_ready_o), .op0_i(req0_op_i),
    .addr0_i(req0_addr_i), .data0_i(req0_data_i),
    .v1_i(req1_valid_i), .r1_o(req1_ready_o), .op1_i(req1_op_i),
    .addr1_i(req1_addr_i), .data1_i(req1_data_i),
    .wb_full_i(wb_full), .wb_free_idx_i(wb_free_idx),
    .wb_alloc_o(wb_alloc), .wb_inc_o(wb_inc_in),
    .up_valid_o, .up_ready_i, .up_op_o, .up_addr_o, .up_data_o, .up_tag_o
  );

  fcs_wait_buf #(.DATA_W(DATA_W), .WB_DEPTH(WB_DEPTH)) u_wbuf (
    .clk_i, .rst_ni,
    .alloc_i(wb_alloc), .alloc_idx_i(wb_free_idx), .alloc_inc_i(wb_inc_in),
    .rel_i(wb_rel), .rel_idx_i(wb_rel_idx), .rel_inc_o(wb_inc_out),
    .full_o(wb_full), .free_idx_o(wb_free_idx)
  );

  fcs_rsp_split #(.DATA_W(DATA_W), .WB_DEPTH(WB_DEPTH)) u_split (
    .clk_i, .rst_ni,
    .up_rsp_valid_i, .up_rsp_ready_o, .up_rsp_tag_i, .up_rsp_data_i,
    .rel_o(wb_rel), .rel_idx_o(wb_rel_idx), .rel_inc_i(wb_inc_out),
    .rsp0_valid_o, .rsp0_ready_i, .rsp0_data_o,
    .rsp1_valid_o, .rsp1_ready_i, .rsp1_data_o
  );

  // R1: a combined upstream request is always a fetch-and-add
  assert_comb_is_faa_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_valid_o && up_tag_o[IDX_W]) |-> (up_op_o == OP_FAA && req0_ready_o == req1_ready_o));
endmodule

// File: tb/fa_comb_switch_test.sv
module fa_comb_switch_test;
  localparam int AW = 8, DW = 16, WBD = 4, TW = 3;
  localparam logic [1:0] LD = 2'd0, ST = 2'd1, FA = 2'd2;

  logic clk = 0, rst_n = 0;
  always #5 clk = ~clk;

  logic v0 = 0, v1 = 0, up_ready = 1, rdy0 = 1, rdy1 = 1, reply_en = 0;
  logic [1:0] op0 = 0, op1 = 0;
  logic [AW-1:0] a0 = 0, a1 = 0;
  logic [DW-1:0] d0 = 0, d1 = 0;
  logic r0, r1, up_valid, up_rsp_ready, rsp0_valid, rsp1_valid;
  logic [1:0] up_op;
  logic [AW-1:0] up_addr;
  logic [DW-1:0] up_data, rsp0_data, rsp1_data;
  logic [TW-1:0] up_tag;

  logic [DW-1:0] mem [256];
  logic [TW-1:0] q_tag [16];
  logic [DW-1:0] q_dat [16];
  int q_wr = 0, q_rd = 0, n_up = 0;
  logic [DW-1:0] log0 [64], log1 [64];
  int n0 = 0, n1 = 0;
  int checks = 0, errors = 0;
  bit done = 0;

  wire up_rsp_valid = reply_en && (q_wr != q_rd);
  wire [TW-1:0] up_rsp_tag = q_tag[q_rd[3:0]];
  wire [DW-1:0] up_rsp_data = q_dat[q_rd[3:0]];

  fa_comb_switch #(.ADDR_W(AW), .DATA_W(DW), .WB_DEPTH(WBD)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .req0_valid_i(v0), .req0_ready_o(r0), .req0_op_i(op0), .req0_addr_i(a0), .req0_data_i(d0),
    .req1_valid_i(v1), .req1_ready_o(r1), .req1_op_i(op1), .req1_addr_i(a1), .req1_data_i(d1),
    .up_valid_o(up_valid), .up_ready_i(up_ready), .up_op_o(up_op), .up_addr_o(up_addr),
    .up_data_o(up_data), .up_tag_o(up_tag),
    .up_rsp_valid_i(up_rsp_valid), .up_rsp_ready_o(up_rsp_ready),
    .up_rsp_tag_i(up_rsp_tag), .up_rsp_data_i(up_rsp_data),
    .rsp0_valid_o(rsp0_valid), .rsp0_ready_i(rdy0), .rsp0_data_o(rsp0_data),
    .rsp1_valid_o(rsp1_valid), .rsp1_ready_i(rdy1), .rsp1_data_o(rsp1_data)
  );

  initial for (int i = 0; i < 256; i++) mem[i] = '0;

  // upstream memory model and response logger
  always @(posedge clk) begin
    if (rst_n && up_valid && up_ready) begin
      q_tag[q_wr[3:0]] <= up_tag;
      q_dat[q_wr[3:0]] <= mem[up_addr];
      q_wr <= q_wr + 1;
      n_up <= n_up + 1;
      if (up_op == ST) mem[up_addr] <= up_data;
      else if (up_op == FA) mem[up_addr] <= mem[up_addr] + up_data;
    end
    if (up_rsp_valid && up_rsp_ready) q_rd <= q_rd + 1;
    if (rsp0_valid && rdy0) begin log0[n0] <= rsp0_data; n0 <= n0 + 1; end
    if (rsp1_valid && rdy1) begin log1[n1] <= rsp1_data; n1 <= n1 + 1; end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_req(input logic [1:0] o0, input logic [AW-1:0] x0, input logic [DW-1:0] y0,
                         input logic [1:0] o1, input logic [AW-1:0] x1, input logic [DW-1:0] y1,
                         input bit e0, input bit e1);
    op0 = o0; a0 = x0; d0 = y0; op1 = o1; a1 = x1; d1 = y1; v0 = e0; v1 = e1;
    #1;
  endtask

  // run until both presented requests are accepted
  task automatic drain_req();
    while (v0 || v1) begin
      bit t0, t1;
      t0 = v0 && r0; t1 = v1 && r1;
      @(posedge clk); @(negedge clk);
      if (t0) v0 = 0;
      if (t1) v1 = 0;
      #1;
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(!up_valid && !rsp0_valid && !rsp1_valid, "R8 valids after reset", up_valid, 0);
    chk(up_rsp_ready, "R8 reply ready after reset", up_rsp_ready, 1);
  endtask

  task automatic t_combine();
    int b0 = n0, b1 = n1;
    reply_en = 0;
    set_req(FA, 8'd5, 16'd3, FA, 8'd5, 16'd7, 1, 1);
    chk(up_valid && up_op == FA && up_addr == 8'd5, "R1 merged op/addr", up_addr, 5);
    chk(up_data == 16'd10, "R1 summed increment", up_data, 10);
    chk(r0 && r1, "R1 both ready", {r0, r1}, 3);
    chk(up_tag[2] == 1'b1, "R6 combined tag bit", up_tag, 4);
    drain_req();
    chk(!up_valid, "R1 single upstream request", up_valid, 0);
    reply_en = 1;
    wait_cyc(4);
    chk(n0 == b0 + 1 && log0[b0] == 16'd0, "R2 first requester gets v", log0[b0], 0);
    chk(n1 == b1 + 1 && log1[b1] == 16'd3, "R2 second gets v+inc0", log1[b1], 3);
    chk(mem[5] == 16'd10, "R9 memory sum", mem[5], 10);
  endtask

  task automatic t_forward();
    int b0 = n0, b1 = n1;
    reply_en = 1;
    set_req(ST, 8'd7, 16'd55, LD, 8'd0, 16'd0, 1, 0);
    drain_req();
    set_req(LD, 8'd7, 16'd0, LD, 8'd7, 16'd0, 1, 1);
    chk(up_tag == 3'b000 && up_op == LD, "R3 R6 input 0 first", up_tag, 0);
    chk(r0 && !r1, "R3 input 1 waits", r1, 0);
    chk(up_data == 16'd0 && up_addr == 8'd7, "R4 loads not merged", up_data, 0);
    @(posedge clk); @(negedge clk); v0 = 0; #1;
    chk(up_valid && up_tag == 3'b001 && r1, "R3 R6 input 1 next", up_tag, 1);
    drain_req();
    wait_cyc(4);
    chk(n0 == b0 + 2 && log0[b0 + 1] == 16'd55, "R6 load routed to 0", log0[b0 + 1], 55);
    chk(n1 == b1 + 1 && log1[b1] == 16'd55, "R6 load routed to 1", log1[b1], 55);
  endtask

  task automatic t_no_merge();
    int u = n_up;
    reply_en = 1;
    set_req(FA, 8'd1, 16'd5, FA, 8'd2, 16'd6, 1, 1);
    chk(up_tag[2] == 1'b0 && !r1, "R4 different address", up_tag, 0);
    drain_req();
    set_req(FA, 8'd3, 16'd4, LD, 8'd3, 16'd0, 1, 1);
    chk(up_tag[2] == 1'b0 && up_data == 16'd4, "R4 mixed opcodes", up_data, 4);
    drain_req();
    wait_cyc(4);
    chk(n_up == u + 4, "R4 four upstream requests", n_up - u, 4);
    chk(mem[1] == 16'd5 && mem[2] == 16'd6 && mem[3] == 16'd4, "R9 separate adds", mem[2], 6);
  endtask

  task automatic t_full();
    int b0 = n0, b1 = n1;
    reply_en = 0;
    for (int k = 0; k < WBD; k++) begin
      set_req(FA, 8'd9, 16'd1, FA, 8'd9, 16'd2, 1, 1);
      chk(up_tag[2] == 1'b1, "R1 pair merged", up_tag, 4);
      drain_req();
    end
    set_req(FA, 8'd9, 16'd1, FA, 8'd9, 16'd2, 1, 1);
    chk(up_valid && up_tag == 3'b000 && !r1, "R5 full buffer forwards", up_tag, 0);
    drain_req();
    reply_en = 1;
    wait_cyc(16);
    chk(mem[9] == 16'd15, "R9 total after full", mem[9], 15);
    for (int k = 0; k < 5; k++) begin
      chk(log0[b0 + k] == 16'(3 * k), "R2 R5 input 0 sequence", log0[b0 + k], 3 * k);
      chk(log1[b1 + k] == 16'(3 * k + 1), "R2 R5 input 1 sequence", log1[b1 + k], 3 * k + 1);
    end
  endtask

  task automatic t_backpressure();
    int b0 = n0, b1 = n1;
    reply_en = 1; rdy0 = 0;
    set_req(FA, 8'd20, 16'd4, FA, 8'd20, 16'd5, 1, 1);
    drain_req();
    wait_cyc(4);
    chk(rsp0_valid && rsp0_data == 16'd0, "R7 response held", rsp0_data, 0);
    chk(n1 == b1 + 1 && log1[b1] == 16'd4, "R2 second under stall", log1[b1], 4);
    set_req(LD, 8'd20, 16'd0, LD, 8'd0, 16'd0, 1, 0);
    drain_req();
    wait_cyc(3);
    chk(up_rsp_valid && !up_rsp_ready, "R7 reply blocked", up_rsp_ready, 0);
    chk(rsp0_valid && rsp0_data == 16'd0, "R7 not overwritten", rsp0_data, 0);
    rdy0 = 1;
    wait_cyc(4);
    chk(n0 == b0 + 2 && log0[b0] == 16'd0 && log0[b0 + 1] == 16'd9, "R7 order kept",
        log0[b0 + 1], 9);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_combine();
    t_forward();
    t_no_merge();
    t_full();
    t_backpressure();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule